// File: doc/BRIEF.md
# Byte-wide boot memory loader

This block runs once after power-up and after every reset. It copies a program image from a slow external ROM that is one byte wide into an on-chip program RAM with 24-bit words. For the whole copy it holds the processor core in reset. It drives the ROM address and a boot-memory select strobe, and it packs three consecutive bytes into each program word. Each finished word goes out on a one-cycle write port.

A 3-bit switch input supplies the upper ROM address bits, so eight separate images can live in one ROM. A 4-bit wait setting fixes how many clock cycles each byte address is held. The block never uses a setting below a fixed floor of 3 cycles, which suits a 250 ns part at 10 MHz. Both inputs are captured once, when the load starts.

When the last word has been written, the block releases the core reset and pulses a done flag for one cycle. It then stays idle until the next reset. A reset that arrives in the middle of a load abandons that load, and the next load starts again from word 0.

Top module: `boot_loader`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `core_rst` is 1 and `rom_sel`, `pm_we` and `boot_done` are 0. The load then starts without any further input.
- R2: A load writes exactly 1024 words, once each, with `pm_addr` running 0, 1, ..., 1023 in order.
- R3: Word w carries ROM byte 3w in bits [23:16], byte 3w+1 in bits [15:8] and byte 3w+2 in bits [7:0].
- R4: During a read, `rom_addr[14:12]` holds the captured page and `rom_addr[11:0]` holds the byte index 3w+b, where b is 0, 1 or 2. Over one load the index covers 0 to 3071.
- R5: Each byte address is held with `rom_sel` high for exactly W consecutive cycles, where W is `wait_cfg` or 3, whichever is larger. The byte is taken at the end of the last of those cycles. After every third byte there is one write cycle with `rom_sel` low, and the next read follows it directly.
- R6: `page_sel` and `wait_cfg` are captured in the first cycle after reset release. Changes to them later in the load have no effect on `rom_addr`, on the read timing or on the data written.
- R7: `core_rst` falls in the cycle after the write of word 1023. `boot_done` is high for exactly that one cycle. After it, `rom_sel`, `pm_we` and `boot_done` stay 0 and `core_rst` stays 0.
- R8: A reset during a load aborts it. The next load begins again at byte index 0 and word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; starts a new load when released |
| page_sel | input | 3 | Image select switches, used as the ROM upper address bits |
| wait_cfg | input | 4 | Cycles per byte read, raised to 3 if smaller |
| rom_data | input | 8 | Byte returned by the external ROM |
| rom_addr | output | 15 | ROM byte address {page, byte index} |
| rom_sel | output | 1 | Boot-memory select strobe, high while a byte is read |
| pm_we | output | 1 | Program RAM write strobe, one cycle per word |
| pm_addr | output | 10 | Program RAM word address |
| pm_wdata | output | 24 | Packed program word |
| core_rst | output | 1 | Holds the processor core in reset while high |
| boot_done | output | 1 | One-cycle pulse when the load completes |

## Verification
Some properties are checked on every cycle. The ROM address must stay still within a byte read, and the page bits must stay still across reads. The wait limit can never drop below the floor. Every write must come right after a read, and every write except the last must lead straight into the next read. Done must be a single-cycle pulse that coincides with the fall of the core reset.

Other behaviour can only be shown by the bench scenarios against a model that counts cycles:
- the exact read length for different wait settings;
- the byte order within each word;
- the full count of 1024 words;
- switch changes during a load being ignored;
- a load cut short by reset restarting from word 0.

// File: rtl/boot_ld_pkg.sv
package boot_ld_pkg;
    typedef enum logic [2:0] {
        LD_START,
        LD_READ,
        LD_WRITE,
        LD_FIN,
        LD_IDLE
    } ld_state_e;
endpackage

// File: rtl/boot_wait_timer.sv
module boot_wait_timer #(
    parameter int CFG_W    = 4,
    parameter int MIN_WAIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CFG_W-1:0] cfg,
    input  logic             run,
    output logic             last
);
    typedef struct packed {
        logic [CFG_W-1:0] lim;
        logic [CFG_W-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    assign last = run && (s_q.cnt == s_q.lim - CFG_W'(1));

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.lim = (cfg < CFG_W'(MIN_WAIT)) ? CFG_W'(MIN_WAIT) : cfg;
            s_d.cnt = '0;
        end else if (run) begin
            s_d.cnt = last ? '0 : s_q.cnt + CFG_W'(1);
        end else begin
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.lim <= CFG_W'(MIN_WAIT);
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R5: a read never runs with a limit below the floor
    assert_lim_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (s_q.lim >= CFG_W'(MIN_WAIT)));
endmodule

// File: rtl/boot_byte_packer.sv
module boot_byte_packer #(
    parameter int BYTE_W = 8,
    parameter int BPW    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift_en,
    input  logic [BYTE_W-1:0]     din,
    output logic [BYTE_W*BPW-1:0] word
);
    localparam int WORD_W = BYTE_W * BPW;

    logic [WORD_W-1:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (shift_en) begin
            acc_d = {acc_q[WORD_W-BYTE_W-1:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign word = acc_q;
endmodule

// File: rtl/boot_seq.sv
module boot_seq
    import boot_ld_pkg::*;
#(
    parameter int WORDS  = 1024,
    parameter int BPW    = 3,
    parameter int PAGE_W = 3,
    localparam int NBYTES  = WORDS * BPW,
    localparam int BADDR_W = $clog2(NBYTES),
    localparam int WADDR_W = $clog2(WORDS),
    localparam int SUB_W   = (BPW > 1) ? $clog2(BPW) : 1,
    localparam int ROM_AW  = PAGE_W + BADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PAGE_W-1:0]  page_sel,
    input  logic               byte_last,
    output logic               tmr_load,
    output logic               tmr_run,
    output logic [ROM_AW-1:0]  rom_addr,
    output logic               rom_sel,
    output logic               pm_we,
    output logic [WADDR_W-1:0] pm_addr,
    output logic               core_rst,
    output logic               done
);
    typedef struct packed {
        ld_state_e          st;
        logic [PAGE_W-1:0]  page;
        logic [BADDR_W-1:0] bidx;
        logic [SUB_W-1:0]   sub;
        logic [WADDR_W-1:0] widx;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            LD_START: begin
                s_d.page = page_sel;
                s_d.bidx = '0;
                s_d.sub  = '0;
                s_d.widx = '0;
                s_d.st   = LD_READ;
            end
            LD_READ: begin
                if (byte_last) begin
                    s_d.bidx = s_q.bidx + BADDR_W'(1);
                    if (s_q.sub == SUB_W'(BPW - 1)) begin
                        s_d.sub = '0;
                        s_d.st  = LD_WRITE;
                    end else begin
                        s_d.sub = s_q.sub + SUB_W'(1);
                    end
                end
            end
            LD_WRITE: begin
                if (s_q.widx == WADDR_W'(WORDS - 1)) begin
                    s_d.st = LD_FIN;
                end else begin
                    s_d.widx = s_q.widx + WADDR_W'(1);
                    s_d.st   = LD_READ;
                end
            end
            LD_FIN:  s_d.st = LD_IDLE;
            default: s_d.st = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= LD_START;
            s_q.page <= '0;
            s_q.bidx <= '0;
            s_q.sub  <= '0;
            s_q.widx <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tmr_load = (s_q.st == LD_START);
    assign tmr_run  = (s_q.st == LD_READ);
    assign rom_sel  = (s_q.st == LD_READ);
    assign rom_addr = {s_q.page, s_q.bidx};
    assign pm_we    = (s_q.st == LD_WRITE);
    assign pm_addr  = s_q.widx;
    assign core_rst = (s_q.st == LD_START) || (s_q.st == LD_READ) || (s_q.st == LD_WRITE);
    assign done     = (s_q.st == LD_FIN);

    // R5: address is steady inside one byte read
    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel && $past(rom_sel) && !$past(byte_last)) |-> $stable(rom_addr));
    // R6: page bits never move between reads of one load
    assert_page_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel && $past(rom_sel)) |-> $stable(rom_addr[ROM_AW-1 -: PAGE_W]));
    // R5: each write directly follows a read
    assert_write_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pm_we |-> $past(rom_sel));
    // R2: a non-final write leads straight into the next read
    assert_next_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_we && (pm_addr != WADDR_W'(WORDS - 1))) |=> rom_sel);
    // R7: done is a single-cycle pulse
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: core reset falls only together with done
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst) |-> done);
endmodule

// File: rtl/boot_loader.sv
module boot_loader #(
    parameter int WORDS    = 1024,
    parameter int BPW      = 3,
    parameter int BYTE_W   = 8,
    parameter int PAGE_W   = 3,
    parameter int CFG_W    = 4,
    parameter int MIN_WAIT = 3,
    localparam int NBYTES  = WORDS * BPW,
    localparam int BADDR_W = $clog2(NBYTES),
    localparam int WADDR_W = $clog2(WORDS),
    localparam int ROM_AW  = PAGE_W + BADDR_W,
    localparam int WORD_W  = BYTE_W * BPW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PAGE_W-1:0]  page_sel,
    input  logic [CFG_W-1:0]   wait_cfg,
    input  logic [BYTE_W-1:0]  rom_data,
    output logic [ROM_AW-1:0]  rom_addr,
    output logic               rom_sel,
    output logic               pm_we,
    output logic [WADDR_W-1:0] pm_addr,
    output logic [WORD_W-1:0]  pm_wdata,
    output logic               core_rst,
    output logic               boot_done
);
    logic tmr_load, tmr_run, byte_last;

    boot_seq #(
        .WORDS (WORDS),
        .BPW   (BPW),
        .PAGE_W(PAGE_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .page_sel (page_sel),
        .byte_last(byte_last),
        .tmr_load (tmr_load),
        .tmr_run  (tmr_run),
        .rom_addr (rom_addr),
        .rom_sel  (rom_sel),
        .pm_we    (pm_we),
        .pm_addr  (pm_addr),
        .core_rst (core_rst),
        .done     (boot_done)
    );

    boot_wait_timer #(
        .CFG_W   (CFG_W),
        .MIN_WAIT(MIN_WAIT)
    ) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .cfg  (wait_cfg),
        .run  (tmr_run),
        .last (byte_last)
    );

    boot_byte_packer #(
        .BYTE_W(BYTE_W),
        .BPW   (BPW)
    ) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(byte_last),
        .din     (rom_data),
        .word    (pm_wdata)
    );
endmodule

// File: tb/tb_boot_loader.sv
`timescale 1ns/1ps
module tb_boot_loader;
    localparam int WORDS = 1024;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [2:0]  page_sel = 3'd5;
    logic [3:0]  wait_cfg = 4'd0;
    logic [7:0]  rom_data;
    logic [14:0] rom_addr;
    logic        rom_sel, pm_we, core_rst, boot_done;
    logic [9:0]  pm_addr;
    logic [23:0] pm_wdata;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int t_cnt = 0;
    bit active = 0, finished = 0;
    logic [2:0] m_page;
    int m_w;
    string scen = "";

    always #2.5 clk = ~clk;

    function automatic logic [7:0] rom_fn(input logic [14:0] a);
        return 8'(a * 7) ^ 8'(a >> 5) ^ 8'h3C;
    endfunction

    assign rom_data = rom_fn(rom_addr);

    boot_loader dut (
        .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .wait_cfg(wait_cfg),
        .rom_data(rom_data), .rom_addr(rom_addr), .rom_sel(rom_sel),
        .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
        .core_rst(core_rst), .boot_done(boot_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s t=%0d actual=%h expected=%h", scen, tag, t_cnt, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        end
    endtask

    // Reference model: expected outputs from the cycle index since release
    always @(negedge clk) begin
        if (active) begin
            int p, done_t, u, w, r, b;
            logic [14:0] base;
            t_cnt++;
            p = 3 * m_w + 1;
            done_t = 1 + WORDS * p;
            if (t_cnt < done_t) begin
                u = t_cnt - 1; w = u / p; r = u % p;
                chk("R1 core_rst held", 32'(core_rst), 1);
                chk("R7 done low", 32'(boot_done), 0);
                if (r < 3 * m_w) begin
                    b = r / m_w;
                    chk("R5 rom_sel read", 32'(rom_sel), 1);
                    chk("R5 pm_we idle", 32'(pm_we), 0);
                    chk("R4 rom_addr", 32'(rom_addr), 32'({m_page, 12'(3 * w + b)}));
                end else begin
                    base = {m_page, 12'(3 * w)};
                    chk("R5 rom_sel write", 32'(rom_sel), 0);
                    chk("R2 pm_we", 32'(pm_we), 1);
                    chk("R2 pm_addr", 32'(pm_addr), 32'(w));
                    chk("R3 pm_wdata", 32'(pm_wdata),
                        32'({rom_fn(base), rom_fn(base + 15'd1), rom_fn(base + 15'd2)}));
                end
            end else begin
                chk("R7 core_rst released", 32'(core_rst), 0);
                chk("R7 done pulse", 32'(boot_done), (t_cnt == done_t) ? 1 : 0);
                chk("R7 rom_sel idle", 32'(rom_sel), 0);
                chk("R7 pm_we idle", 32'(pm_we), 0);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !finished) begin
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            summary();
            $finish;
        end
    end

    task automatic hold_reset(input int n);
        @(negedge clk); #1;
        active = 0;
        rst_n = 0;
        #0.5;
        chk("R8 reset core_rst", 32'(core_rst), 1);
        chk("R8 reset rom_sel", 32'(rom_sel), 0);
        chk("R8 reset pm_we", 32'(pm_we), 0);
        chk("R1 reset done", 32'(boot_done), 0);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_load(input logic [2:0] pg, input logic [3:0] cf);
        @(negedge clk); #1;
        page_sel = pg;
        wait_cfg = cf;
        m_page = pg;
        m_w = (cf < 4'd3) ? 3 : int'(cf);
        rst_n = 1;
        t_cnt = 0;
        active = 1;
        #0.5;
        chk("R1 start core_rst", 32'(core_rst), 1);
        chk("R1 start rom_sel", 32'(rom_sel), 0);
        chk("R1 start pm_we", 32'(pm_we), 0);
    endtask

    task automatic run_to_end();
        int end_t;
        end_t = 1 + WORDS * (3 * m_w + 1) + 20;
        while (t_cnt < end_t) begin
            @(negedge clk); #1;
        end
    endtask

    initial begin
        // Load 1: page 5, wait below floor; switches move mid-load (R6)
        scen = "L1";
        hold_reset(4);
        start_load(3'd5, 4'd0);
        repeat (40) @(negedge clk);
        #1;
        scen = "L1 R6 switches moved";
        page_sel = 3'd2;
        wait_cfg = 4'd9;
        run_to_end();

        // Load 2: aborted by reset mid-way, then restart (R8)
        scen = "L2";
        hold_reset(3);
        start_load(3'd2, 4'd6);
        repeat (3000) @(negedge clk);
        scen = "L2 R8 abort";
        hold_reset(5);
        scen = "L2 R8 restart";
        start_load(3'd7, 4'd4);
        run_to_end();

        // Load 3: page 0, longest wait
        scen = "L3";
        hold_reset(2);
        start_load(3'd0, 4'd15);
        run_to_end();

        active = 0;
        summary();
        $finish;
    end
endmodule